// File: doc/BRIEF.md
# Forward Link Parity Error Counter

This block tallies the parity errors that a forward-link frame checker flags, one pulse per bad frame. Errors are only counted while the link reports lock and while the checker-enable bit is set. In normal operation the errors land in a 16-bit count that stops rising once it equals a programmable 16-bit ceiling. A sticky flag records that at least one error has been accepted. A level-held clear bit holds both the count and the flag at zero for as long as it stays set.

While the self-test input is high, accepted errors go to a separate 8-bit count instead of the main one. That count saturates at 255 and is zeroed on each entry into self-test.

Software reaches the block through a small byte-wide register port. Reading the low count byte also captures the high byte into a shadow register, so a low-then-high read pair always describes a single value of the count. Register map (3-bit address): 0 ceiling low byte, 1 ceiling high byte, 2 control (bit 0 checker enable, bit 1 clear), 3 count low byte, 4 captured count high byte, 5 status (bit 0 error flag), 6 self-test count. Address 7 reads zero.

Top module: `fwd_parity_err_cnt`

## Requirements
- R1: After reset the ceiling reads 0x0100 (address 0 reads 0x00, address 1 reads 0x01), control reads 0x01, and the count, the status flag and the self-test count all read 0.
- R2: A parity pulse that arrives while lock is high, the enable bit (control bit 0) is 1, the clear bit (control bit 1) is 0 and self-test is low raises the 16-bit count by exactly one in the following cycle.
- R3: The count never increments while it is greater than or equal to the ceiling. It therefore holds at the ceiling value.
- R4: Status bit 0 becomes 1 on the first accepted normal-mode error and stays 1 until cleared. This holds even when the ceiling is 0 and the count stays 0.
- R5: While control bit 1 is 1, the count and the status flag read 0 and pulses are not counted. The bit keeps reading back 1 until software writes it to 0.
- R6: With control bit 0 at 0, parity pulses change neither the count nor the flag.
- R7: With lock low, parity pulses change neither the count nor the flag.
- R8: While self-test is high, accepted pulses raise the 8-bit self-test count (address 6) instead of the main count. The self-test count saturates at 255 and holds its value after self-test ends.
- R9: A low-to-high transition of self-test clears the self-test count. A pulse in that first cycle is not counted.
- R10: A read of address 3 captures the high count byte. Later reads of address 4 return that captured byte until the next read of address 3.
- R11: Read data and the valid strobe appear in the cycle after the read request. The strobe is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lock_i | input | 1 | Link lock indication |
| par_err_i | input | 1 | Parity error pulse, one per bad frame |
| selftest_i | input | 1 | Self-test mode active |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read request |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| rvalid_o | output | 1 | Read data valid |

## Verification
A parity pulse or a register write sampled at one rising edge is visible in the state from that edge onward. A read requested at the next edge therefore already returns the updated value. Read data arrives one edge after the request. The driver pushes the expected byte into a queue when it raises the request. The monitor pops and compares on the falling edge after the strobe rises, so every comparison falls in the cycle where the result is due. An unexpected strobe, or an expectation still queued at the end, counts as an R11 failure.

// File: rtl/fwd_parity_err_cnt.sv
module fwd_parity_err_cnt #(
  parameter logic [15:0] THR_RESET = 16'h0100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lock_i,
  input  logic       par_err_i,
  input  logic       selftest_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       rvalid_o
);
  localparam logic [7:0] ST_MAX = 8'hFF;

  logic [15:0] thr_q, cnt_q;
  logic [7:0]  st_cnt_q, hi_cap_q;
  logic        en_q, clr_q, flag_q, st_q;

  wire hit      = par_err_i & lock_i & en_q;
  wire st_enter = selftest_i & ~st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= THR_RESET;
      en_q  <= 1'b1;
      clr_q <= 1'b0;
    end else if (wr_en_i) begin
      case (addr_i)
        3'd0: thr_q[7:0]  <= wdata_i;
        3'd1: thr_q[15:8] <= wdata_i;
        3'd2: begin
          en_q  <= wdata_i[0];
          clr_q <= wdata_i[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (clr_q) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (hit && !selftest_i) begin
      flag_q <= 1'b1;
      if (cnt_q < thr_q) cnt_q <= cnt_q + 16'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= 1'b0;
      st_cnt_q <= '0;
    end else begin
      st_q <= selftest_i;
      if (st_enter)                                 st_cnt_q <= '0;
      else if (hit && selftest_i && st_cnt_q != ST_MAX) st_cnt_q <= st_cnt_q + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      hi_cap_q <= '0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) begin
        case (addr_i)
          3'd0: rdata_o <= thr_q[7:0];
          3'd1: rdata_o <= thr_q[15:8];
          3'd2: rdata_o <= {6'd0, clr_q, en_q};
          3'd3: begin
            rdata_o  <= cnt_q[7:0];
            hi_cap_q <= cnt_q[15:8];
          end
          3'd4: rdata_o <= hi_cap_q;
          3'd5: rdata_o <= {7'd0, flag_q};
          3'd6: rdata_o <= st_cnt_q;
          default: rdata_o <= 8'h00;
        endcase
      end
    end
  end

  p_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_q && cnt_q >= thr_q) |=> cnt_q == $past(cnt_q));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> (cnt_q == 16'd0 && !flag_q));

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_q) |=> flag_q);

  p_gate_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !clr_q) |=> ($stable(cnt_q) && $stable(flag_q)));

  p_gate_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_i && !clr_q) |=> ($stable(cnt_q) && $stable(flag_q)));

  p_selftest_main_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (selftest_i && !clr_q) |=> $stable(cnt_q));

  p_selftest_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q && st_cnt_q == ST_MAX) |=> st_cnt_q == ST_MAX);

  p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rvalid_o);
endmodule

// File: tb/fwd_parity_err_cnt_tb_top.sv
module fwd_parity_err_cnt_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lock_i = 1'b0, par_err_i = 1'b0, selftest_i = 1'b0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       rvalid_o;

  int n_checks = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  fwd_parity_err_cnt dut_i (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .par_err_i(par_err_i),
    .selftest_i(selftest_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    rd_en_i = 1'b1; addr_i = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic pulses(input int n);
    par_err_i = 1'b1;
    repeat (n) @(negedge clk);
    par_err_i = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rvalid_o) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R11: strobe without request, actual %02h expected none", rdata_o);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata_o !== e) begin
          n_fail++;
          $display("FAIL %s: actual %02h expected %02h", t, rdata_o, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, 8'h00, "R1"); rd(3'd1, 8'h01, "R1"); rd(3'd2, 8'h01, "R1");
    rd(3'd3, 8'h00, "R1"); rd(3'd4, 8'h00, "R1"); rd(3'd5, 8'h00, "R1");
    rd(3'd6, 8'h00, "R1");
    // R2 / R4 basic counting
    lock_i = 1'b1;
    pulses(3);
    rd(3'd3, 8'h03, "R2"); rd(3'd4, 8'h00, "R2"); rd(3'd5, 8'h01, "R4");
    // R7 no lock
    lock_i = 1'b0; pulses(4); lock_i = 1'b1;
    rd(3'd3, 8'h03, "R7");
    // R6 disabled
    wr(3'd2, 8'h00); pulses(4); rd(3'd3, 8'h03, "R6"); rd(3'd5, 8'h01, "R6");
    wr(3'd2, 8'h01);
    // R5 level-held clear
    wr(3'd2, 8'h03); pulses(2);
    rd(3'd2, 8'h03, "R5"); rd(3'd3, 8'h00, "R5"); rd(3'd5, 8'h00, "R5");
    wr(3'd2, 8'h01);
    // R3 ceiling
    wr(3'd0, 8'h05); wr(3'd1, 8'h00);
    rd(3'd0, 8'h05, "R3"); rd(3'd1, 8'h00, "R3");
    pulses(8); rd(3'd3, 8'h05, "R3"); rd(3'd5, 8'h01, "R4");
    // R4 flag with zero ceiling
    wr(3'd2, 8'h03); wr(3'd2, 8'h01); wr(3'd0, 8'h00);
    rd(3'd5, 8'h00, "R4");
    pulses(2); rd(3'd3, 8'h00, "R4"); rd(3'd5, 8'h01, "R4");
    // R10 coherent two-byte read
    wr(3'd2, 8'h03); wr(3'd2, 8'h01); wr(3'd1, 8'h01);
    pulses(255);
    rd(3'd3, 8'hFF, "R10");
    pulses(1);
    rd(3'd4, 8'h00, "R10");
    rd(3'd3, 8'h00, "R10"); rd(3'd4, 8'h01, "R10");
    pulses(5);
    rd(3'd3, 8'h00, "R3"); rd(3'd4, 8'h01, "R3");
    // R8 self-test
    selftest_i = 1'b1; @(negedge clk);
    pulses(3);
    rd(3'd6, 8'h03, "R8"); rd(3'd3, 8'h00, "R8"); rd(3'd4, 8'h01, "R8");
    pulses(260); rd(3'd6, 8'hFF, "R8");
    selftest_i = 1'b0; pulses(2); rd(3'd6, 8'hFF, "R8");
    // R9 re-entry clears, first-cycle pulse ignored
    selftest_i = 1'b1; pulses(1); rd(3'd6, 8'h00, "R9");
    // R11 idle strobe
    repeat (2) @(negedge clk);
    n_checks++;
    if (rvalid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: rvalid actual %b expected 0", rvalid_o);
    end
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R11: pending reads actual %0d expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule